// File: doc/BRIEF.md
# Unaligned Access Splitter

This block sits between a processor-side request port and a memory bus on which every transfer must be naturally aligned. It takes one read or write request at a time, with a byte address, a size (byte, halfword or word) and up to four bytes of write data. An aligned request goes out as one transfer. An unaligned request is broken into a chain of smaller transfers, each naturally aligned. The requester does nothing extra and is stalled until the whole chain has finished.

Each piece drives byte-lane strobes and carries its bytes on the lanes picked by the low address bits, in little-endian order. The memory honours the strobes for every size, so a partial write never needs a read-modify-write. For reads, the bytes returned by each piece are gathered into one right-justified result. That result is handed back together with a single-cycle response pulse.

Top module: `unaligned_splitter`

## Requirements
- R1: The size code `up_size` is 0 for a byte, 1 for a halfword and 2 for a word, and code 3 is treated as a word. A naturally aligned request of any size produces exactly one downstream transfer, whose strobe covers all of its bytes (4'b1111 for an aligned word).
- R2: Every downstream transfer is naturally aligned. One lane means any address, two lanes means an even address, and four lanes means an address that is a multiple of 4. A transfer never asserts three lanes or an odd-address halfword.
- R3: The pieces walk the requested span in ascending address order, and each piece is the largest aligned size that fits the bytes left. A word at 0x55 is issued as a byte at 0x55 (strobe 4'b0010), then a halfword at 0x56 (4'b1100), then a byte at 0x58 (4'b0001).
- R4: A halfword at byte offset 1 or 3 becomes two byte transfers. At offset 3 the second byte goes to the next word address, on lane 0.
- R5: Request byte k (`up_wdata[8k+7:8k]`) is placed on lane (addr+k) mod 4 of `dn_wdata` in the piece that carries it. The lowest strobe set is the lane given by `dn_addr[1:0]`.
- R6: Read byte k comes from address addr+k and is placed at `up_rdata[8k+7:8k]`. Bits above the requested size read as zero.
- R7: `up_ready` is high only while idle. It stays low from acceptance until after the response pulse.
- R8: `up_rvalid` is high for exactly one cycle. After a write it comes in the cycle after the last downstream handshake. After a read it comes in the cycle after the last data cycle. `up_ready` is high again in the cycle after the pulse. An aligned write answers two cycles after acceptance and an aligned read three, both with no stalls.
- R9: While `dn_valid` is high and `dn_ready` is low, the downstream address, strobe, direction and write data hold their values.
- R10: After reset, `up_ready` is 1, `dn_valid` is 0 and `up_rvalid` is 0.
- R11: `dn_rdata` is sampled only in the cycle after a read handshake, and its value in every other cycle has no effect on the result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| up_valid | input | 1 | Request present |
| up_ready | output | 1 | Request accepted when high together with up_valid |
| up_write | input | 1 | 1 for write, 0 for read |
| up_size | input | 2 | 0 byte, 1 halfword, 2 or 3 word |
| up_addr | input | AW | Byte address of the request |
| up_wdata | input | 32 | Right-justified write data |
| up_rvalid | output | 1 | One-cycle completion pulse |
| up_rdata | output | 32 | Right-justified read result, valid with up_rvalid |
| dn_valid | output | 1 | Downstream transfer present |
| dn_ready | input | 1 | Downstream accepts the transfer |
| dn_write | output | 1 | Direction of the transfer |
| dn_addr | output | AW | Byte address of the aligned piece |
| dn_strb | output | DW/8 | Byte-lane strobes |
| dn_wdata | output | DW | Lane-steered write data |
| dn_rdata | input | DW | Read data, one cycle after the read handshake |

## Verification
On every cycle, the assertions check that each downstream piece is naturally aligned and that its strobe starts on the lane its address selects. They also check that the upstream port stays stalled while a piece is outstanding, that the response is a single pulse, and that the transfer holds steady during a downstream stall. Some behaviour can only be shown by the bench scenarios, because it depends on the whole transaction rather than on one cycle. This covers the exact piece sequence and piece count per offset and size, the data that reaches memory on each lane, the assembled read value against a reference byte model, and the response latency in cycles. The bench drives junk on the read bus outside the data cycles, so a read that sampled at the wrong time would return wrong bytes.

// File: rtl/uas_pkg.sv
package uas_pkg;

   typedef enum logic [1:0] {
      SZ_BYTE = 2'd0,
      SZ_HALF = 2'd1,
      SZ_WORD = 2'd2
   } size_e;

   typedef enum logic [1:0] {
      ST_IDLE,
      ST_ISSUE,
      ST_RDATA,
      ST_RESP
   } state_e;

   // number of bytes a size code spans; code 3 is taken as a word
   function automatic logic [2:0] span_bytes(input logic [1:0] sz);
      case (sz)
         SZ_BYTE: span_bytes = 3'd1;
         SZ_HALF: span_bytes = 3'd2;
         default: span_bytes = 3'd4;
      endcase
   endfunction

endpackage

// File: rtl/uas_piece_plan.sv
// Chooses the next aligned piece: the largest power-of-two size that both
// divides the current lane offset and fits the bytes still to move.
module uas_piece_plan #(
   parameter int LANES = 4,
   parameter int LW    = 2,
   parameter int CW    = 3
) (
   input  logic [LW-1:0]    lane,
   input  logic [CW-1:0]    remain,
   output logic [CW-1:0]    len,
   output logic [LANES-1:0] strb
);

   always_comb begin
      len = '0;
      for (int s = 0; s <= LW; s++) begin
         if (s <= 2 && (int'(lane) % (1 << s)) == 0 && (1 << s) <= int'(remain))
            len = CW'(1 << s);
      end
   end

   always_comb begin
      for (int i = 0; i < LANES; i++)
         strb[i] = (i >= int'(lane)) && (i < int'(lane) + int'(len));
   end

endmodule

// File: rtl/uas_lane_steer.sv
// Write side: moves the pending low bytes onto the addressed lanes.
// Read side: drops the lanes of one returned piece into the result bytes.
module uas_lane_steer #(
   parameter int DW    = 32,
   parameter int LANES = 4,
   parameter int LW    = 2,
   parameter int CW    = 3
) (
   input  logic [31:0]   wbuf,
   input  logic [LW-1:0] lane,
   output logic [DW-1:0] lane_wdata,
   input  logic [31:0]   rbuf_in,
   input  logic [DW-1:0] rd_data,
   input  logic [LW-1:0] rd_lane,
   input  logic [CW-1:0] rd_off,
   input  logic [CW-1:0] rd_len,
   output logic [31:0]   rbuf_out
);

   assign lane_wdata = DW'(wbuf) << {lane, 3'b000};

   for (genvar j = 0; j < 4; j++) begin : g_rbyte
      logic [7:0] pick;
      always_comb begin
         int src;
         src  = int'(rd_lane) + j - int'(rd_off);
         pick = rbuf_in[8*j +: 8];
         if (j >= int'(rd_off) && j < int'(rd_off) + int'(rd_len) &&
             src >= 0 && src < LANES)
            pick = rd_data[8*src +: 8];
      end
      assign rbuf_out[8*j +: 8] = pick;
   end

endmodule

// File: rtl/unaligned_splitter.sv
module unaligned_splitter
   import uas_pkg::*;
#(
   parameter int AW = 32,
   parameter int DW = 32
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            up_valid,
   output logic            up_ready,
   input  logic            up_write,
   input  logic [1:0]      up_size,
   input  logic [AW-1:0]   up_addr,
   input  logic [31:0]     up_wdata,
   output logic            up_rvalid,
   output logic [31:0]     up_rdata,
   output logic            dn_valid,
   input  logic            dn_ready,
   output logic            dn_write,
   output logic [AW-1:0]   dn_addr,
   output logic [DW/8-1:0] dn_strb,
   output logic [DW-1:0]   dn_wdata,
   input  logic [DW-1:0]   dn_rdata
);

   localparam int LANES = DW / 8;
   localparam int LW    = $clog2(LANES);
   localparam int CW    = 3;

   initial begin : chk_params
      assert (DW == 32 || DW == 64) else $error("DW must be 32 or 64");
      assert (AW > LW) else $error("AW too small for lane select");
   end

   state_e        st_q;
   logic [AW-1:0] addr_q;
   logic [CW-1:0] remain_q;
   logic [CW-1:0] off_q;
   logic [31:0]   wbuf_q;
   logic [31:0]   rbuf_q;
   logic          wr_q;
   logic [LW-1:0] rd_lane_q;
   logic [CW-1:0] rd_off_q;
   logic [CW-1:0] rd_len_q;

   logic [CW-1:0]    len;
   logic [LANES-1:0] strb;
   logic [DW-1:0]    lane_wdata;
   logic [31:0]      rbuf_next;
   logic             hs;

   uas_piece_plan #(.LANES(LANES), .LW(LW), .CW(CW)) u_plan (
      .lane   (addr_q[LW-1:0]),
      .remain (remain_q),
      .len    (len),
      .strb   (strb)
   );

   uas_lane_steer #(.DW(DW), .LANES(LANES), .LW(LW), .CW(CW)) u_steer (
      .wbuf       (wbuf_q),
      .lane       (addr_q[LW-1:0]),
      .lane_wdata (lane_wdata),
      .rbuf_in    (rbuf_q),
      .rd_data    (dn_rdata),
      .rd_lane    (rd_lane_q),
      .rd_off     (rd_off_q),
      .rd_len     (rd_len_q),
      .rbuf_out   (rbuf_next)
   );

   assign hs        = (st_q == ST_ISSUE) && dn_ready;
   assign up_ready  = (st_q == ST_IDLE);
   assign up_rvalid = (st_q == ST_RESP);
   assign up_rdata  = rbuf_q;
   assign dn_valid  = (st_q == ST_ISSUE);
   assign dn_write  = wr_q;
   assign dn_addr   = addr_q;
   assign dn_strb   = strb;
   assign dn_wdata  = lane_wdata;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st_q      <= ST_IDLE;
         addr_q    <= '0;
         remain_q  <= '0;
         off_q     <= '0;
         wbuf_q    <= '0;
         rbuf_q    <= '0;
         wr_q      <= 1'b0;
         rd_lane_q <= '0;
         rd_off_q  <= '0;
         rd_len_q  <= '0;
      end else begin
         case (st_q)
            ST_IDLE: begin
               if (up_valid) begin
                  addr_q   <= up_addr;
                  remain_q <= span_bytes(up_size);
                  off_q    <= '0;
                  wbuf_q   <= up_wdata;
                  rbuf_q   <= '0;
                  wr_q     <= up_write;
                  st_q     <= ST_ISSUE;
               end
            end
            ST_ISSUE: begin
               if (hs) begin
                  addr_q    <= addr_q + AW'(len);
                  remain_q  <= remain_q - len;
                  off_q     <= off_q + len;
                  wbuf_q    <= wbuf_q >> {len, 3'b000};
                  rd_lane_q <= addr_q[LW-1:0];
                  rd_off_q  <= off_q;
                  rd_len_q  <= len;
                  if (!wr_q)              st_q <= ST_RDATA;
                  else if (remain_q == len) st_q <= ST_RESP;
               end
            end
            ST_RDATA: begin
               rbuf_q <= rbuf_next;
               st_q   <= (remain_q == '0) ? ST_RESP : ST_ISSUE;
            end
            default: st_q <= ST_IDLE;
         endcase
      end
   end

endmodule

// File: rtl/uas_checker.sv
module uas_checker #(
   parameter int AW    = 32,
   parameter int LANES = 4,
   parameter int LW    = 2,
   parameter int DW    = 32
) (
   input logic             clk,
   input logic             rst_n,
   input logic             up_ready,
   input logic             up_rvalid,
   input logic             dn_valid,
   input logic             dn_ready,
   input logic             dn_write,
   input logic [AW-1:0]    dn_addr,
   input logic [LANES-1:0] dn_strb,
   input logic [DW-1:0]    dn_wdata
);

   assert_strb_size_R2: assert property (@(posedge clk) disable iff (!rst_n)
      dn_valid |-> ($countones(dn_strb) == 1 || $countones(dn_strb) == 2 ||
                    $countones(dn_strb) == 4));

   assert_half_even_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (dn_valid && $countones(dn_strb) == 2) |-> (dn_addr[0] == 1'b0));

   assert_word_aligned_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (dn_valid && $countones(dn_strb) == 4) |-> (dn_addr[1:0] == 2'b00));

   assert_lane_start_R5: assert property (@(posedge clk) disable iff (!rst_n)
      dn_valid |-> dn_strb[dn_addr[LW-1:0]]);

   assert_stalled_up_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (dn_valid || up_rvalid) |-> !up_ready);

   assert_resp_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
      up_rvalid |=> !up_rvalid);

   assert_hold_stall_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (dn_valid && !dn_ready) |=> (dn_valid && $stable(dn_addr) &&
         $stable(dn_strb) && $stable(dn_write) && $stable(dn_wdata)));

endmodule

bind unaligned_splitter uas_checker #(
   .AW(AW), .LANES(DW/8), .LW($clog2(DW/8)), .DW(DW)
) u_uas_checker (
   .clk       (clk),
   .rst_n     (rst_n),
   .up_ready  (up_ready),
   .up_rvalid (up_rvalid),
   .dn_valid  (dn_valid),
   .dn_ready  (dn_ready),
   .dn_write  (dn_write),
   .dn_addr   (dn_addr),
   .dn_strb   (dn_strb),
   .dn_wdata  (dn_wdata)
);

// File: tb/unaligned_splitter_bench.sv
module unaligned_splitter_bench;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        up_valid = 1'b0;
   logic        up_ready;
   logic        up_write = 1'b0;
   logic [1:0]  up_size = 2'd0;
   logic [31:0] up_addr = '0;
   logic [31:0] up_wdata = '0;
   logic        up_rvalid;
   logic [31:0] up_rdata;
   logic        dn_valid;
   logic        dn_ready;
   logic        dn_write;
   logic [31:0] dn_addr;
   logic [3:0]  dn_strb;
   logic [31:0] dn_wdata;
   logic [31:0] dn_rdata;

   always #5 clk = ~clk;

   unaligned_splitter #(.AW(32), .DW(32)) u_unaligned_splitter (.*);

   // memory model, stall pattern and piece log
   logic [7:0]  mem [64];
   logic [7:0]  refm [64];
   logic        rd_pend;
   logic [31:0] rd_word;
   logic        stall_en = 1'b0;
   logic [31:0] cyc;
   int          log_n;
   logic [31:0] log_addr [64];
   logic [3:0]  log_strb [64];
   logic [31:0] log_wdata [64];

   assign dn_ready = !stall_en || cyc[0];
   // R11: junk on the read bus outside the data cycle
   assign dn_rdata = rd_pend ? rd_word : 32'hC3C3_3C3C;

   always @(posedge clk) begin
      if (!rst_n) begin
         for (int i = 0; i < 64; i++) mem[i] <= 8'(i * 7 + 3);
         rd_pend <= 1'b0;
         rd_word <= '0;
         cyc     <= '0;
         log_n   <= 0;
      end else begin
         cyc     <= cyc + 1;
         rd_pend <= dn_valid && dn_ready && !dn_write;
         if (dn_valid && dn_ready) begin
            for (int i = 0; i < 4; i++) begin
               if (dn_write && dn_strb[i])
                  mem[{dn_addr[5:2], 2'(i)}] <= dn_wdata[8*i +: 8];
               rd_word[8*i +: 8] <= mem[{dn_addr[5:2], 2'(i)}];
            end
            log_addr[log_n % 64]  <= dn_addr;
            log_strb[log_n % 64]  <= dn_strb;
            log_wdata[log_n % 64] <= dn_wdata;
            log_n <= log_n + 1;
         end
      end
   end

   int errors = 0;
   int checks = 0;
   int wd = 0;

   task automatic check(input bit ok, input string req, input logic [31:0] act,
                        input logic [31:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   function automatic int nbytes(input logic [1:0] sz);
      return (sz == 2'd0) ? 1 : (sz == 2'd1) ? 2 : 4;
   endfunction

   function automatic logic [31:0] ref_read(input logic [1:0] sz, input logic [31:0] a);
      logic [31:0] v = '0;
      for (int k = 0; k < nbytes(sz); k++) v[8*k +: 8] = refm[(a + k) % 64];
      return v;
   endfunction

   task automatic ref_write(input logic [1:0] sz, input logic [31:0] a, input logic [31:0] d);
      for (int k = 0; k < nbytes(sz); k++) refm[(a + k) % 64] = d[8*k +: 8];
   endtask

   int          t_k, t_np, t_start;
   logic [31:0] t_rd;

   task automatic run(input bit w, input logic [1:0] sz, input logic [31:0] a,
                      input logic [31:0] d, input string tag);
      bit busy_bad = 0;
      @(negedge clk);
      t_start  = log_n;
      up_valid = 1'b1; up_write = w; up_size = sz; up_addr = a; up_wdata = d;
      @(negedge clk);
      up_valid = 1'b0;
      t_k = 1;
      while (!up_rvalid && t_k < 300) begin
         if (up_ready) busy_bad = 1;
         @(negedge clk);
         t_k++;
      end
      t_rd = up_rdata;
      t_np = log_n - t_start;
      check(!busy_bad && up_rvalid, {"R7 ready low while busy ", tag}, {31'd0, busy_bad}, 32'd0);
      @(negedge clk);
      check(up_ready && !up_rvalid, {"R8 single pulse then ready ", tag},
            {30'd0, up_ready, up_rvalid}, 32'd2);
      if (w) ref_write(sz, a, d);
   endtask

   // table: write, size, addr, wdata, expected piece count
   localparam int NV = 13;
   localparam logic [45:0] VEC [NV] = '{
      {1'b0, 2'd0, 8'h05, 32'h0,         3'd1},
      {1'b0, 2'd1, 8'h06, 32'h0,         3'd1},
      {1'b0, 2'd2, 8'h08, 32'h0,         3'd1},
      {1'b0, 2'd1, 8'h09, 32'h0,         3'd2},
      {1'b0, 2'd1, 8'h0B, 32'h0,         3'd2},
      {1'b0, 2'd2, 8'h0D, 32'h0,         3'd3},
      {1'b0, 2'd2, 8'h0E, 32'h0,         3'd2},
      {1'b1, 2'd2, 8'h15, 32'h1122_3344, 3'd3},
      {1'b1, 2'd1, 8'h1B, 32'h0000_BEEF, 3'd2},
      {1'b1, 2'd2, 8'h22, 32'hCAFE_F00D, 3'd2},
      {1'b1, 2'd3, 8'h30, 32'h7766_5544, 3'd1},
      {1'b0, 2'd2, 8'h15, 32'h0,         3'd3},
      {1'b0, 2'd2, 8'h3F, 32'h0,         3'd3}
   };

   initial begin
      for (int i = 0; i < 64; i++) refm[i] = 8'(i * 7 + 3);
      repeat (3) @(negedge clk);
      // R10: reset values
      check(up_ready && !dn_valid && !up_rvalid, "R10 reset state",
            {29'd0, up_ready, dn_valid, up_rvalid}, 32'h4);
      rst_n = 1'b1;

      for (int v = 0; v < NV; v++) begin
         logic        w;
         logic [1:0]  sz;
         logic [31:0] a, d, exp;
         w  = VEC[v][45];
         sz = VEC[v][44:43];
         a  = {24'd0, VEC[v][42:35]};
         d  = VEC[v][34:3];
         exp = ref_read(sz, a);
         run(w, sz, a, d, "table");
         // R1/R3: piece count per size and offset
         check(t_np == int'(VEC[v][2:0]), "R3 piece count", t_np, {29'd0, VEC[v][2:0]});
         if (!w) check(t_rd == exp, "R6 read assembly", t_rd, exp);
      end

      // R5: memory contents after the table writes
      begin
         bit ok = 1;
         for (int i = 0; i < 64; i++) if (mem[i] !== refm[i]) ok = 0;
         check(ok, "R5 written bytes reach memory", {31'd0, ok}, 32'd1);
      end

      // R3: word at 0x55
      run(1'b0, 2'd2, 32'h55, 32'h0, "R3");
      check(log_addr[t_start % 64] == 32'h55 && log_strb[t_start % 64] == 4'b0010,
            "R3 piece0", log_addr[t_start % 64], 32'h55);
      check(log_addr[(t_start + 1) % 64] == 32'h56 && log_strb[(t_start + 1) % 64] == 4'b1100,
            "R3 piece1", log_addr[(t_start + 1) % 64], 32'h56);
      check(log_addr[(t_start + 2) % 64] == 32'h58 && log_strb[(t_start + 2) % 64] == 4'b0001,
            "R3 piece2", log_addr[(t_start + 2) % 64], 32'h58);
      check(t_k == 7, "R8 three-piece read latency", t_k, 32'd7);
      check(t_rd == ref_read(2'd2, 32'h55), "R11 read ignores junk bus", t_rd,
            ref_read(2'd2, 32'h55));

      // R4: halfword at offset 3 crosses into next word
      run(1'b0, 2'd1, 32'h0B, 32'h0, "R4");
      check(t_np == 2 && log_addr[(t_start + 1) % 64] == 32'h0C &&
            log_strb[(t_start + 1) % 64] == 4'b0001, "R4 second byte next word",
            log_addr[(t_start + 1) % 64], 32'h0C);

      // R1/R8: aligned word write
      run(1'b1, 2'd2, 32'h20, 32'hA1B2_C3D4, "R1");
      check(t_np == 1 && log_strb[t_start % 64] == 4'b1111, "R1 aligned word single transfer",
            {28'd0, log_strb[t_start % 64]}, 32'hF);
      check(t_k == 2, "R8 aligned write latency", t_k, 32'd2);

      // R8: aligned read latency
      run(1'b0, 2'd0, 32'h07, 32'h0, "R8");
      check(t_k == 3, "R8 aligned read latency", t_k, 32'd3);
      check(t_rd == {24'd0, refm[7]}, "R6 byte read upper bits zero", t_rd, {24'd0, refm[7]});

      // R5: byte write on lane 3
      run(1'b1, 2'd0, 32'h23, 32'h0000_005A, "R5");
      check(log_strb[t_start % 64] == 4'b1000 && log_wdata[t_start % 64][31:24] == 8'h5A,
            "R5 byte steered to lane 3", log_wdata[t_start % 64], 32'h5A00_0000);

      // R9: unaligned word read under downstream stalls
      stall_en = 1'b1;
      run(1'b0, 2'd2, 32'h29, 32'h0, "R9");
      check(t_rd == ref_read(2'd2, 32'h29), "R9 read with stalls", t_rd, ref_read(2'd2, 32'h29));
      run(1'b1, 2'd2, 32'h2D, 32'h0BAD_F00D, "R9");
      run(1'b0, 2'd2, 32'h2D, 32'h0, "R9");
      check(t_rd == 32'h0BAD_F00D, "R9 write then read with stalls", t_rd, 32'h0BAD_F00D);
      stall_en = 1'b0;

      // R2: every logged piece naturally aligned
      begin
         bit ok = 1;
         for (int i = 0; i < 64 && i < log_n; i++) begin
            if ($countones(log_strb[i]) == 2 && log_addr[i][0]) ok = 0;
            if ($countones(log_strb[i]) == 4 && log_addr[i][1:0] != 2'b00) ok = 0;
            if ($countones(log_strb[i]) == 3) ok = 0;
         end
         check(ok, "R2 pieces aligned", {31'd0, ok}, 32'd1);
      end

      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   always @(posedge clk) begin
      wd <= wd + 1;
      if (wd > 100000) begin
         errors = errors + 1;
         checks = checks + 1;
         $display("FAIL watchdog actual=%0d expected=%0d", wd, 100000);
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

endmodule